// File: doc/BRIEF.md
# Cache-Bypass Indexed Load/Store Unit

This unit executes uncached indexed loads and stores for a 64-bit register machine. The decoder hands it one operation at a time: a load/store flag, an access size code, the values of a base register, an index register and a source register, and a flag that is set when the base register specifier is zero. The unit adds base and index to form the effective address. When the specifier flag is set, it uses zero as the base. It then issues exactly one single-beat request on a valid/ready memory port, and every such request carries the cache-inhibit bit.

Byte order is big-endian. The byte at the effective address is the most significant byte of the access, and the low three address bits select the byte lanes. Load data comes back on a response port. The unit right-aligns it, zero-extends it and presents it on a result port with a one-cycle valid pulse. A store sends only the low-order bits of the source value. If the address is not naturally aligned to the access size, the unit raises an alignment-error pulse and sends nothing to memory.

Top module: `cbx_ldst_unit`

## Requirements
- R1: When `op_base_zero` is 1, the base operand is zero and `base_val` has no effect on the address. Otherwise the base operand is `base_val`.
- R2: `mem_addr` is the 64-bit sum of the base operand and `index_val`. Any carry out of bit 63 is dropped.
- R3: Size codes are 0=1 byte, 1=2 bytes, 2=4 bytes and 3=8 bytes, for both loads and stores. `mem_size` repeats the code and `mem_we` is 1 for stores only. Address offset k=addr[2:0] maps to byte lane 7-k, and lane L is `mem_be[L]` with data bits [8L+7:8L]. For a store of n bytes, the lanes 7-k down to 8-k-n are enabled and all other lanes are disabled. Source byte n-1 goes to lane 7-k, and so on down to source byte 0.
- R4: A load of n bytes returns, in `res_data`, the read lanes 7-k down to 8-k-n in the same big-endian order. Result bits above 8n are zero.
- R5: Every request has `mem_ci` = 1.
- R6: For a misaligned address (addr mod n != 0), `op_align_err` is 1 for exactly the one cycle after the operation is taken. No request is issued and the unit stays idle.
- R7: `busy` is 1 from the cycle after an aligned operation is taken. It clears at the store's request handshake or at the load's response. While `busy` is 1, `op_valid` is ignored.
- R8: `res_valid` pulses for exactly one cycle, the cycle after a load response, and never for a store.
- R9: While `mem_req_valid` is 1 and `mem_req_ready` is 0, the request holds its address, data and byte enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| op_valid | input | 1 | Operation presented (taken when not busy) |
| op_store | input | 1 | 1 = store, 0 = load |
| op_size | input | 2 | Access size code |
| op_base_zero | input | 1 | Base register specifier is zero |
| base_val | input | 64 | Base register contents |
| index_val | input | 64 | Index register contents |
| src_val | input | 64 | Store source register contents |
| busy | output | 1 | Operation in flight |
| op_align_err | output | 1 | Misaligned operation rejected |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_addr | output | 64 | Effective address |
| mem_we | output | 1 | Write request |
| mem_size | output | 2 | Access size code |
| mem_be | output | 8 | Byte-lane enables |
| mem_wdata | output | 64 | Lane-placed store data |
| mem_ci | output | 1 | Cache-inhibit marker |
| mem_rsp_valid | input | 1 | Load response valid |
| mem_rsp_rdata | input | 64 | Load response data |
| res_valid | output | 1 | Load result valid pulse |
| res_data | output | 64 | Zero-extended load result |

## Verification
The bench drives a base value that wraps past 2^64 and checks that the carry is dropped. It also sets the zero-specifier flag together with a non-zero base value; a design that ignores the flag puts the wrong address on the port. Each size is exercised at non-zero lane offsets, so a little-endian or mis-shifted lane placement shows up as wrong byte enables, wrong write data or wrong upper result bits. Further tests cover misaligned addresses, stalled request handshakes and operations presented while busy. These catch a design that issues a request anyway, lets the request drift during a stall, or starts a second access.

// File: rtl/cbx_pkg.sv
package cbx_pkg;
  localparam int XLEN   = 64;
  localparam int NLANES = XLEN / 8;
  localparam int OFS_W  = $clog2(NLANES);
  localparam int SZ_W   = 2;

  typedef enum logic [1:0] {ST_IDLE = 2'd0, ST_REQ = 2'd1, ST_WAIT = 2'd2} fsm_e;

  // number of bytes for a size code
  function automatic logic [OFS_W:0] size_bytes(input logic [SZ_W-1:0] sz);
    size_bytes = (OFS_W+1)'(1) << sz;
  endfunction

  // mask of the low 8*n bits
  function automatic logic [XLEN-1:0] size_mask(input logic [SZ_W-1:0] sz);
    case (sz)
      2'd0:    size_mask = XLEN'(64'h0000_0000_0000_00FF);
      2'd1:    size_mask = XLEN'(64'h0000_0000_0000_FFFF);
      2'd2:    size_mask = XLEN'(64'h0000_0000_FFFF_FFFF);
      default: size_mask = '1;
    endcase
  endfunction

  // lane index of the least significant byte of the access (big-endian)
  function automatic logic [OFS_W:0] low_lane(input logic [OFS_W-1:0] ofs,
                                              input logic [SZ_W-1:0] sz);
    low_lane = (OFS_W+1)'(NLANES) - {1'b0, ofs} - size_bytes(sz);
  endfunction

  function automatic logic is_misaligned(input logic [OFS_W-1:0] ofs,
                                         input logic [SZ_W-1:0] sz);
    logic [OFS_W:0] low_bits;
    low_bits = size_bytes(sz) - (OFS_W+1)'(1);
    is_misaligned = ({1'b0, ofs} & low_bits) != '0;
  endfunction
endpackage

// File: rtl/cbx_addr_gen.sv
module cbx_addr_gen
  import cbx_pkg::*;
#(
  parameter int AW = XLEN
) (
  input  logic                 base_zero,
  input  logic [AW-1:0]        base_val,
  input  logic [AW-1:0]        index_val,
  input  logic [SZ_W-1:0]      size,
  output logic [AW-1:0]        ea,
  output logic                 misaligned
);
  logic [AW-1:0] base_opnd;

  assign base_opnd  = base_zero ? '0 : base_val;
  assign ea         = base_opnd + index_val;   // carry out discarded
  assign misaligned = is_misaligned(ea[OFS_W-1:0], size);
endmodule

// File: rtl/cbx_store_lanes.sv
module cbx_store_lanes
  import cbx_pkg::*;
#(
  parameter int DW = XLEN,
  localparam int LN = DW / 8
) (
  input  logic [DW-1:0]     src,
  input  logic [SZ_W-1:0]   size,
  input  logic [OFS_W-1:0]  ofs,
  output logic [DW-1:0]     wdata,
  output logic [LN-1:0]     be
);
  logic [OFS_W:0] lo;
  logic [OFS_W:0] hi_excl;

  assign lo      = low_lane(ofs, size);
  assign hi_excl = lo + size_bytes(size);
  assign wdata   = (src & size_mask(size)) << {lo, 3'b000};

  for (genvar l = 0; l < LN; l++) begin : g_lane
    assign be[l] = ((OFS_W+1)'(l) >= lo) && ((OFS_W+1)'(l) < hi_excl);
  end
endmodule

// File: rtl/cbx_load_align.sv
module cbx_load_align
  import cbx_pkg::*;
#(
  parameter int DW = XLEN
) (
  input  logic [DW-1:0]     rdata,
  input  logic [SZ_W-1:0]   size,
  input  logic [OFS_W-1:0]  ofs,
  output logic [DW-1:0]     result
);
  logic [OFS_W:0] lo;

  assign lo     = low_lane(ofs, size);
  assign result = (rdata >> {lo, 3'b000}) & size_mask(size);
endmodule

// File: rtl/cbx_ldst_unit.sv
module cbx_ldst_unit
  import cbx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic              op_store,
  input  logic [1:0]        op_size,
  input  logic              op_base_zero,
  input  logic [63:0]       base_val,
  input  logic [63:0]       index_val,
  input  logic [63:0]       src_val,
  output logic              busy,
  output logic              op_align_err,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [63:0]       mem_addr,
  output logic              mem_we,
  output logic [1:0]        mem_size,
  output logic [7:0]        mem_be,
  output logic [63:0]       mem_wdata,
  output logic              mem_ci,
  input  logic              mem_rsp_valid,
  input  logic [63:0]       mem_rsp_rdata,
  output logic              res_valid,
  output logic [63:0]       res_data
);
  fsm_e              state;
  logic [XLEN-1:0]   ea;
  logic              ea_misaligned;
  logic [XLEN-1:0]   st_wdata;
  logic [NLANES-1:0] st_be;
  logic [XLEN-1:0]   ld_result;

  // named events
  logic op_take, op_issue, op_reject, req_fire, rsp_take;

  logic [XLEN-1:0]   req_addr_q;
  logic              req_we_q;
  logic [SZ_W-1:0]   req_size_q;
  logic [NLANES-1:0] req_be_q;
  logic [XLEN-1:0]   req_wdata_q;
  logic              align_err_q;
  logic              res_valid_q;
  logic [XLEN-1:0]   res_data_q;

  cbx_addr_gen #(.AW(XLEN)) u_addr (
    .base_zero (op_base_zero),
    .base_val  (base_val),
    .index_val (index_val),
    .size      (op_size),
    .ea        (ea),
    .misaligned(ea_misaligned)
  );

  cbx_store_lanes #(.DW(XLEN)) u_st (
    .src   (src_val),
    .size  (op_size),
    .ofs   (ea[OFS_W-1:0]),
    .wdata (st_wdata),
    .be    (st_be)
  );

  cbx_load_align #(.DW(XLEN)) u_ld (
    .rdata (mem_rsp_rdata),
    .size  (req_size_q),
    .ofs   (req_addr_q[OFS_W-1:0]),
    .result(ld_result)
  );

  assign op_take   = op_valid && (state == ST_IDLE);
  assign op_issue  = op_take && !ea_misaligned;
  assign op_reject = op_take && ea_misaligned;
  assign req_fire  = (state == ST_REQ) && mem_req_ready;
  assign rsp_take  = (state == ST_WAIT) && mem_rsp_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      req_addr_q  <= '0;
      req_we_q    <= 1'b0;
      req_size_q  <= '0;
      req_be_q    <= '0;
      req_wdata_q <= '0;
      align_err_q <= 1'b0;
      res_valid_q <= 1'b0;
      res_data_q  <= '0;
    end else begin
      align_err_q <= op_reject;
      res_valid_q <= rsp_take;
      if (rsp_take) res_data_q <= ld_result;
      if (op_issue) begin
        req_addr_q  <= ea;
        req_we_q    <= op_store;
        req_size_q  <= op_size;
        req_be_q    <= st_be;
        req_wdata_q <= op_store ? st_wdata : '0;
      end
      case (state)
        ST_IDLE: if (op_issue) state <= ST_REQ;
        ST_REQ:  if (req_fire) state <= req_we_q ? ST_IDLE : ST_WAIT;
        ST_WAIT: if (rsp_take) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy          = (state != ST_IDLE);
  assign op_align_err  = align_err_q;
  assign mem_req_valid = (state == ST_REQ);
  assign mem_addr      = req_addr_q;
  assign mem_we        = req_we_q;
  assign mem_size      = req_size_q;
  assign mem_be        = req_be_q;
  assign mem_wdata     = req_wdata_q;
  assign mem_ci        = 1'b1;
  assign res_valid     = res_valid_q;
  assign res_data      = res_data_q;

  // R9
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_addr)
      && $stable(mem_wdata) && $stable(mem_be));

  // R8
  res_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);

  // R8
  res_load_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> !mem_we && !busy);

  // R6
  align_noreq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_align_err |-> !mem_req_valid && !busy);

  // R3
  be_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> $countones(mem_be) == int'(size_bytes(mem_size)));

  // R7
  busy_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> busy);
endmodule

// File: tb/cbx_ldst_unit_test.sv
`timescale 1ns/1ps
module cbx_ldst_unit_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic op_valid = 0, op_store = 0, op_base_zero = 0;
  logic [1:0] op_size = 0;
  logic [63:0] base_val = 0, index_val = 0, src_val = 0;
  logic busy, op_align_err, mem_req_valid, mem_we, mem_ci, res_valid;
  logic mem_req_ready = 0, mem_rsp_valid = 0;
  logic [63:0] mem_addr, mem_wdata, res_data;
  logic [63:0] mem_rsp_rdata = 0;
  logic [1:0] mem_size;
  logic [7:0] mem_be;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  cbx_ldst_unit uut (.*);

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] e_be(input logic [2:0] k, input int n);
    logic [7:0] b = '0;
    for (int i = 0; i < n; i++) b[7 - (int'(k) + i)] = 1'b1;
    return b;
  endfunction

  function automatic logic [63:0] e_wd(input logic [63:0] s, input logic [2:0] k, input int n);
    logic [63:0] w = '0;
    for (int i = 0; i < n; i++) w[8*(7-(int'(k)+i)) +: 8] = s[8*(n-1-i) +: 8];
    return w;
  endfunction

  function automatic logic [63:0] e_ld(input logic [63:0] r, input logic [2:0] k, input int n);
    logic [63:0] v = '0;
    for (int i = 0; i < n; i++) v[8*(n-1-i) +: 8] = r[8*(7-(int'(k)+i)) +: 8];
    return v;
  endfunction

  task automatic present(input logic st, input logic [1:0] sz, input logic bz,
                         input logic [63:0] b, input logic [63:0] x, input logic [63:0] s);
    op_valid = 1; op_store = st; op_size = sz; op_base_zero = bz;
    base_val = b; index_val = x; src_val = s;
    @(negedge clk);
    op_valid = 0;
  endtask

  task automatic do_load(input string nm, input logic [1:0] sz, input logic bz,
                         input logic [63:0] b, input logic [63:0] x,
                         input logic [63:0] rd, input int stall);
    logic [63:0] ea = (bz ? 64'd0 : b) + x;
    int n = 1 << sz;
    present(1'b0, sz, bz, b, x, 64'hDEAD_BEEF_0BAD_F00D);
    check({nm, " R7 busy after take"}, 64'(busy), 64'd1);
    check({nm, " R2 R1 address"}, mem_addr, ea);
    check({nm, " R5 ci"}, 64'(mem_ci), 64'd1);
    check({nm, " R3 we/size"}, {61'd0, mem_we, mem_size}, {61'd0, 1'b0, sz});
    check({nm, " R3 load be"}, 64'(mem_be), 64'(e_be(ea[2:0], n)));
    for (int c = 0; c < stall; c++) begin
      @(negedge clk);
      check({nm, " R9 held valid"}, 64'(mem_req_valid), 64'd1);
      check({nm, " R9 held addr"}, mem_addr, ea);
    end
    mem_req_ready = 1;
    @(negedge clk);
    mem_req_ready = 0;
    check({nm, " R7 busy waiting"}, {62'd0, busy, mem_req_valid}, {62'd0, 2'b10});
    check({nm, " R8 no early result"}, 64'(res_valid), 64'd0);
    mem_rsp_valid = 1; mem_rsp_rdata = rd;
    @(negedge clk);
    mem_rsp_valid = 0; mem_rsp_rdata = 64'h5A5A_5A5A_5A5A_5A5A;
    check({nm, " R8 result valid"}, 64'(res_valid), 64'd1);
    check({nm, " R4 result data"}, res_data, e_ld(rd, ea[2:0], n));
    check({nm, " R7 idle after rsp"}, 64'(busy), 64'd0);
    @(negedge clk);
    check({nm, " R8 single pulse"}, 64'(res_valid), 64'd0);
  endtask

  task automatic do_store(input string nm, input logic [1:0] sz, input logic bz,
                          input logic [63:0] b, input logic [63:0] x,
                          input logic [63:0] s, input int stall);
    logic [63:0] ea = (bz ? 64'd0 : b) + x;
    int n = 1 << sz;
    present(1'b1, sz, bz, b, x, s);
    check({nm, " R2 R1 address"}, mem_addr, ea);
    check({nm, " R3 we/size"}, {61'd0, mem_we, mem_size}, {61'd0, 1'b1, sz});
    check({nm, " R3 store be"}, 64'(mem_be), 64'(e_be(ea[2:0], n)));
    check({nm, " R3 store data"}, mem_wdata & {{8{mem_be[7]}}, {8{mem_be[6]}}, {8{mem_be[5]}},
          {8{mem_be[4]}}, {8{mem_be[3]}}, {8{mem_be[2]}}, {8{mem_be[1]}}, {8{mem_be[0]}}},
          e_wd(s, ea[2:0], n));
    check({nm, " R5 ci"}, 64'(mem_ci), 64'd1);
    for (int c = 0; c < stall; c++) begin
      @(negedge clk);
      check({nm, " R9 held data"}, mem_wdata & e_wd('1, ea[2:0], n), e_wd(s, ea[2:0], n));
    end
    mem_req_ready = 1;
    @(negedge clk);
    mem_req_ready = 0;
    check({nm, " R7 idle after store"}, {62'd0, busy, mem_req_valid}, 64'd0);
    check({nm, " R8 no store result"}, 64'(res_valid), 64'd0);
    @(negedge clk);
    check({nm, " R8 no store result later"}, 64'(res_valid), 64'd0);
  endtask

  task automatic do_misaligned(input string nm, input logic st, input logic [1:0] sz,
                               input logic [63:0] x);
    present(st, sz, 1'b1, 64'h0, x, 64'h1);
    check({nm, " R6 err pulse"}, 64'(op_align_err), 64'd1);
    check({nm, " R6 no request"}, {62'd0, mem_req_valid, busy}, 64'd0);
    @(negedge clk);
    check({nm, " R6 err ends"}, 64'(op_align_err), 64'd0);
    check({nm, " R6 still idle"}, 64'(mem_req_valid), 64'd0);
  endtask

  task automatic busy_ignore();
    present(1'b0, 2'd3, 1'b1, 64'h0, 64'h100, 64'h0);
    present(1'b1, 2'd0, 1'b1, 64'h0, 64'h777, 64'hAA);
    check("R7 ignored op keeps addr", mem_addr, 64'h100);
    check("R7 ignored op keeps load", 64'(mem_we), 64'd0);
    mem_req_ready = 1;
    @(negedge clk);
    mem_req_ready = 0;
    present(1'b1, 2'd0, 1'b1, 64'h0, 64'h555, 64'hBB);
    check("R7 ignored op in wait", {62'd0, mem_req_valid, busy}, 64'd1);
    mem_rsp_valid = 1; mem_rsp_rdata = 64'h0102_0304_0506_0708;
    @(negedge clk);
    mem_rsp_valid = 0;
    check("R4 full dword", res_data, 64'h0102_0304_0506_0708);
    @(negedge clk);
    check("R7 no late request", {62'd0, mem_req_valid, busy}, 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R7 reset state", {60'd0, busy, mem_req_valid, res_valid, op_align_err}, 64'd0);
    rst_n = 1;
    @(negedge clk);
    do_load("ld byte ofs5", 2'd0, 1'b0, 64'h1000, 64'h5, 64'h1122_3344_5566_7788, 0);
    do_load("ld half ofs6", 2'd1, 1'b0, 64'h2000, 64'h6, 64'hA1B2_C3D4_E5F6_0718, 2);
    do_load("ld word ofs4 r0", 2'd2, 1'b1, 64'hFFFF_0000_0000_0003, 64'h44, 64'hCAFE_BABE_1234_5678, 0);
    do_load("ld dword wrap", 2'd3, 1'b0, 64'hFFFF_FFFF_FFFF_FFF8, 64'h20, 64'h8877_6655_4433_2211, 1);
    do_load("ld byte ofs0", 2'd0, 1'b0, 64'h0, 64'h0, 64'hF0E1_D2C3_B4A5_9687, 0);
    do_store("st byte ofs3", 2'd0, 1'b0, 64'h3000, 64'h3, 64'hFFFF_FFFF_FFFF_FF9C, 0);
    do_store("st half ofs2", 2'd1, 1'b1, 64'h9999, 64'h802, 64'h1234_5678_9ABC_DEF0, 1);
    do_store("st word ofs0", 2'd2, 1'b0, 64'h4000, 64'h0, 64'h0BAD_CAFE_DEAD_BEEF, 0);
    do_store("st dword wrap", 2'd3, 1'b0, 64'hFFFF_FFFF_FFFF_FFF0, 64'h18, 64'h0011_2233_4455_6677, 3);
    do_misaligned("mis half", 1'b0, 2'd1, 64'h1001);
    do_misaligned("mis word", 1'b1, 2'd2, 64'h1006);
    do_misaligned("mis dword", 1'b0, 2'd3, 64'h1004);
    busy_ignore();
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule